// File: doc/BRIEF.md
# Serial Command Register Port

This block is the slave side of a radio transceiver's control port. A host lowers the select line and clocks in a 16-bit command, most significant bit first, on the rising edge of the serial clock. Once the sixteenth bit arrives, the block works out which command it is from the leading bits and loads the matching configuration register. The register contents are output as separate fields for the rest of the chip to use.

Commands are not told apart by a fixed address field. Each class has its own prefix, and the prefixes differ in length. Two command classes return data on the serial output during the frame. A frame that opens with a 0 bit returns a status word provided by neighbouring logic. A frame whose upper byte is 0xB0 returns a received-data byte, starting part-way through the frame. The serial pins are sampled on the system clock, so the serial clock must run well below the system clock.

Top module: `rfcmd_port`

## Requirements
- R1: After reset the fields take these values: configuration byte 0x08 (TX-register enable 0, FIFO enable 0, band 0, crystal load 8); power enables 0x08; frequency word 0x680; transmit data 0xAA; wake-up exponent 0x01 and mantissa 0x96.
- R2: Bits are captured most significant first, on each rising serial clock while select is low. A command takes effect only when the sixteenth rising edge of a frame arrives.
- R3: If select rises before sixteen rising edges have arrived, the frame is discarded and no register changes.
- R4: Only the first sixteen rising edges of a frame are counted. Any further edges change neither the registers nor the serial output.
- R5: Upper byte 0x80 loads the configuration byte from bits 7..0: bit 7 TX-register enable, bit 6 FIFO enable, bits 5..4 band code, bits 3..0 crystal load code.
- R6: Upper byte 0x82 loads the eight power enables from bits 7..0. From bit 7 down they are receiver, baseband, transmitter, synthesizer, oscillator, battery monitor, wake-up timer and clock-output disable.
- R7: A top nibble of 0xA loads the 12-bit frequency word from bits 11..0.
- R8: Upper byte 0xB8 loads the transmit data register from bits 7..0.
- R9: Top three bits 111 load the wake-up exponent from bits 12..8 and the mantissa from bits 7..0.
- R10: A frame whose first bit is 0 is a status read and writes no register. After its k-th rising edge (k from 1 to 16) the serial output shows status bit 16-k, and it holds bit 0 after that.
- R11: A frame whose upper byte is 0xB0 is a data read and writes no register. After rising edge 8+j (j from 0 to 7) the serial output shows data bit 7-j, and after edge 16 it shows 0.
- R12: A 16-bit frame that matches no prefix (for example 0x81xx, 0x98xx or 0xCxxx) changes no register.
- R13: The serial output is 0 one clock after select goes high, and it stays 0 during frames that are not reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial command data in |
| ser_dout | output | 1 | Serial read data out |
| status_word | input | 16 | Status value returned by status reads |
| rx_byte | input | 8 | Received byte returned by data reads |
| tx_reg_en | output | 1 | TX-register enable |
| rx_fifo_en | output | 1 | Receive FIFO enable |
| band_code | output | 2 | Band select code |
| xtal_load | output | 4 | Crystal load code |
| pwr_en | output | 8 | Power enables, receiver at bit 7 |
| freq_word | output | 12 | Carrier frequency word |
| tx_data | output | 8 | Transmit data byte |
| wake_exp | output | 5 | Wake-up period exponent |
| wake_mant | output | 8 | Wake-up period mantissa |

## Verification
Every writable register class is loaded with a nonzero pattern, so a decode that picks the wrong prefix or shifts a field lands a different value. Frames cut off after 10 and 15 bits and frames running 18 bits separate a counter that commits too early from one that keeps counting too long. Frames close to a real prefix (0x81, 0x98, 0xC0, 0xC6) show whether the prefix compare is too loose. Status and data reads use asymmetric words, so a read that starts one edge early or late, or shifts in the wrong order, shows up in the bit-by-bit output comparison.

// File: rtl/rfcmd_pkg.sv
package rfcmd_pkg;
  localparam int CMD_W = 16;
  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam int FIFO_START = 8;

  localparam logic [7:0]  PFX_CFG   = 8'h80;
  localparam logic [7:0]  PFX_PWR   = 8'h82;
  localparam logic [3:0]  PFX_FREQ  = 4'hA;
  localparam logic [7:0]  PFX_RDFF  = 8'hB0;
  localparam logic [7:0]  PFX_TX    = 8'hB8;
  localparam logic [2:0]  PFX_WAKE  = 3'b111;

  localparam logic [7:0]  RST_CFG   = 8'h08;
  localparam logic [7:0]  RST_PWR   = 8'h08;
  localparam logic [11:0] RST_FREQ  = 12'h680;
  localparam logic [7:0]  RST_TX    = 8'hAA;
  localparam logic [12:0] RST_WAKE  = 13'h0196;
endpackage

// File: rtl/rfcmd_shifter.sv
module rfcmd_shifter
  import rfcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             sel_n,
  input  logic             din,
  output logic             bit_stb,
  output logic [CNT_W-1:0] bit_num,
  output logic [CMD_W-1:0] word_nxt,
  output logic             frame_stb,
  output logic [CMD_W-1:0] frame_word
);
  logic             sck_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CMD_W-1:0] shf_q, shf_d;
  logic             stb_q, stb_d;

  always_comb begin
    bit_stb  = sck & ~sck_q & ~sel_n & (cnt_q < CNT_W'(CMD_W));
    bit_num  = cnt_q + 1'b1;
    word_nxt = {shf_q[CMD_W-2:0], din};
    cnt_d    = cnt_q;
    shf_d    = shf_q;
    stb_d    = 1'b0;
    if (sel_n) begin
      cnt_d = '0;
      shf_d = '0;
    end else if (bit_stb) begin
      cnt_d = bit_num;
      shf_d = word_nxt;
      stb_d = (cnt_q == CNT_W'(CMD_W - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cnt_q <= '0;
      shf_q <= '0;
      stb_q <= 1'b0;
    end else begin
      sck_q <= sck;
      cnt_q <= cnt_d;
      shf_q <= shf_d;
      stb_q <= stb_d;
    end
  end

  assign frame_stb  = stb_q;
  assign frame_word = shf_q;

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CMD_W));

  // R2
  frame_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (cnt_q == CNT_W'(CMD_W)) || $past(sel_n));
endmodule

// File: rtl/rfcmd_readback.sv
module rfcmd_readback
  import rfcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             bit_stb,
  input  logic [CNT_W-1:0] bit_num,
  input  logic [CMD_W-1:0] word_nxt,
  input  logic [CMD_W-1:0] status_word,
  input  logic [7:0]       rx_byte,
  output logic             dout
);
  logic [CMD_W-1:0] out_q, out_d;

  always_comb begin
    out_d = out_q;
    if (sel_n) begin
      out_d = '0;
    end else if (bit_stb) begin
      if (bit_num == CNT_W'(1) && !word_nxt[0])
        out_d = status_word;
      else if (bit_num == CNT_W'(FIFO_START) && word_nxt[7:0] == PFX_RDFF)
        out_d = {rx_byte, {(CMD_W-8){1'b0}}};
      else
        out_d = {out_q[CMD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign dout = out_q[CMD_W-1];

  // R13
  idle_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> !dout);
endmodule

// File: rtl/rfcmd_regfile.sv
module rfcmd_regfile
  import rfcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_stb,
  input  logic [CMD_W-1:0] frame_word,
  output logic [7:0]       cfg,
  output logic [7:0]       pwr,
  output logic [11:0]      freq,
  output logic [7:0]       txd,
  output logic [12:0]      wake
);
  logic [7:0]  cfg_q, cfg_d, pwr_q, pwr_d, txd_q, txd_d;
  logic [11:0] freq_q, freq_d;
  logic [12:0] wake_q, wake_d;
  logic [CMD_W-1:0] w;

  // longest prefixes are tested first
  always_comb begin
    w      = frame_word;
    cfg_d  = cfg_q;
    pwr_d  = pwr_q;
    freq_d = freq_q;
    txd_d  = txd_q;
    wake_d = wake_q;
    if (frame_stb) begin
      if (!w[CMD_W-1]) begin
        // status read, nothing stored
      end else if (w[15:8] == PFX_RDFF) begin
        // data read, nothing stored
      end else if (w[15:8] == PFX_TX)   txd_d  = w[7:0];
      else if (w[15:8] == PFX_CFG)      cfg_d  = w[7:0];
      else if (w[15:8] == PFX_PWR)      pwr_d  = w[7:0];
      else if (w[15:12] == PFX_FREQ)    freq_d = w[11:0];
      else if (w[15:13] == PFX_WAKE)    wake_d = w[12:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= RST_CFG;
      pwr_q  <= RST_PWR;
      freq_q <= RST_FREQ;
      txd_q  <= RST_TX;
      wake_q <= RST_WAKE;
    end else begin
      cfg_q  <= cfg_d;
      pwr_q  <= pwr_d;
      freq_q <= freq_d;
      txd_q  <= txd_d;
      wake_q <= wake_d;
    end
  end

  assign cfg  = cfg_q;
  assign pwr  = pwr_q;
  assign freq = freq_q;
  assign txd  = txd_q;
  assign wake = wake_q;

  // R3
  hold_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable({cfg_q, pwr_q, freq_q, txd_q, wake_q}));

  // R10
  status_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !frame_word[CMD_W-1]) |=> $stable({cfg_q, pwr_q, freq_q, txd_q, wake_q}));
endmodule

// File: rtl/rfcmd_port.sv
module rfcmd_port
  import rfcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_sel_n,
  input  logic        ser_din,
  output logic        ser_dout,
  input  logic [15:0] status_word,
  input  logic [7:0]  rx_byte,
  output logic        tx_reg_en,
  output logic        rx_fifo_en,
  output logic [1:0]  band_code,
  output logic [3:0]  xtal_load,
  output logic [7:0]  pwr_en,
  output logic [11:0] freq_word,
  output logic [7:0]  tx_data,
  output logic [4:0]  wake_exp,
  output logic [7:0]  wake_mant
);
  logic [1:0]       rst_sync_q;
  logic             rst_s_n;
  logic             bit_stb, frame_stb;
  logic [CNT_W-1:0] bit_num;
  logic [CMD_W-1:0] word_nxt, frame_word;
  logic [7:0]       cfg;
  logic [12:0]      wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  rfcmd_shifter u_shf (
    .clk(clk), .rst_n(rst_s_n), .sck(ser_clk), .sel_n(ser_sel_n),
    .din(ser_din), .bit_stb(bit_stb), .bit_num(bit_num),
    .word_nxt(word_nxt), .frame_stb(frame_stb), .frame_word(frame_word)
  );

  rfcmd_readback u_rdb (
    .clk(clk), .rst_n(rst_s_n), .sel_n(ser_sel_n), .bit_stb(bit_stb),
    .bit_num(bit_num), .word_nxt(word_nxt), .status_word(status_word),
    .rx_byte(rx_byte), .dout(ser_dout)
  );

  rfcmd_regfile u_reg (
    .clk(clk), .rst_n(rst_s_n), .frame_stb(frame_stb),
    .frame_word(frame_word), .cfg(cfg), .pwr(pwr_en), .freq(freq_word),
    .txd(tx_data), .wake(wake)
  );

  assign tx_reg_en  = cfg[7];
  assign rx_fifo_en = cfg[6];
  assign band_code  = cfg[5:4];
  assign xtal_load  = cfg[3:0];
  assign wake_exp   = wake[12:8];
  assign wake_mant  = wake[7:0];
endmodule

// File: tb/rfcmd_port_tb.sv
module rfcmd_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sel_n = 1'b1, din = 1'b0;
  logic dout;
  logic [15:0] st_w = 16'h0;
  logic [7:0]  rx_b = 8'h0;
  logic tx_en, ff_en;
  logic [1:0] band;
  logic [3:0] xl;
  logic [7:0] pwr, txd, wm;
  logic [11:0] fq;
  logic [4:0] we;

  int checks = 0, fails = 0;
  bit cmp_on = 0, done = 0;
  string cur_req = "R1";

  logic [7:0]  m_cfg = 8'h08, m_pwr = 8'h08, m_tx = 8'hAA;
  logic [11:0] m_freq = 12'h680;
  logic [12:0] m_wake = 13'h0196;

  always #10 clk = ~clk;

  rfcmd_port dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(sck), .ser_sel_n(sel_n),
    .ser_din(din), .ser_dout(dout), .status_word(st_w), .rx_byte(rx_b),
    .tx_reg_en(tx_en), .rx_fifo_en(ff_en), .band_code(band),
    .xtal_load(xl), .pwr_en(pwr), .freq_word(fq), .tx_data(txd),
    .wake_exp(we), .wake_mant(wm)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference compare on every idle clock
  always @(negedge clk) begin
    if (cmp_on) begin
      check(cur_req, {24'h0, tx_en, ff_en, band, xl}, {24'h0, m_cfg});
      check(cur_req, {24'h0, pwr}, {24'h0, m_pwr});
      check(cur_req, {20'h0, fq}, {20'h0, m_freq});
      check(cur_req, {24'h0, txd}, {24'h0, m_tx});
      check(cur_req, {19'h0, we, wm}, {19'h0, m_wake});
      check("R13 idle dout", {31'h0, dout}, 32'h0);
    end
  end

  function automatic void model_apply(input logic [15:0] w);
    if (!w[15]) ;
    else if (w[15:8] == 8'hB0) ;
    else if (w[15:8] == 8'hB8) m_tx = w[7:0];
    else if (w[15:8] == 8'h80) m_cfg = w[7:0];
    else if (w[15:8] == 8'h82) m_pwr = w[7:0];
    else if (w[15:12] == 4'hA) m_freq = w[11:0];
    else if (w[15:13] == 3'b111) m_wake = w[12:0];
  endfunction

  task automatic frame(input string req, input logic [15:0] w, input int nbits);
    logic expb;
    cmp_on = 0;
    cur_req = req;
    @(negedge clk);
    sel_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      int kk;
      @(negedge clk);
      sck = 1'b0;
      din = (i < 16) ? w[15-i] : 1'b1;
      @(negedge clk);
      sck = 1'b1;
      @(negedge clk);
      kk = (i + 1 > 16) ? 16 : i + 1;
      if (!w[15]) expb = st_w[16-kk];
      else if (w[15:8] == 8'hB0 && kk >= 8 && kk <= 15) expb = rx_b[15-kk];
      else expb = 1'b0;
      check(!w[15] ? "R10 status bit" : (w[15:8] == 8'hB0 ? "R11 data bit" : "R13 dout"),
            {31'h0, dout}, {31'h0, expb});
      sck = 1'b0;
    end
    @(negedge clk);
    sel_n = 1'b1;
    din = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (nbits >= 16) model_apply(w);
    cmp_on = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 cfg", {24'h0, tx_en, ff_en, band, xl}, 32'h08);
    check("R1 pwr", {24'h0, pwr}, 32'h08);
    check("R1 freq", {20'h0, fq}, 32'h680);
    check("R1 tx", {24'h0, txd}, 32'hAA);
    check("R1 wake", {19'h0, we, wm}, 32'h0196);
    cmp_on = 1;
    @(negedge clk);

    frame("R5", 16'h80D7, 16);
    check("R5 band", {30'h0, band}, 32'h1);
    frame("R6", 16'h8239, 16);
    frame("R7", 16'hA640, 16);
    check("R2 msb-first freq", {20'h0, fq}, 32'h640);
    frame("R8", 16'hB855, 16);
    frame("R9", 16'hE000, 16);
    frame("R9", 16'hF5A3, 16);
    check("R9 exp", {27'h0, we}, 32'h15);

    st_w = 16'hA5C3;
    frame("R10", 16'h0000, 16);
    st_w = 16'h3C0F;
    frame("R10", 16'h7FFF, 18);
    rx_b = 8'h96;
    frame("R11", 16'hB000, 16);
    rx_b = 8'h5A;
    frame("R11", 16'hB000, 17);

    frame("R3", 16'hA123, 10);
    frame("R3", 16'h82FF, 15);
    frame("R4", 16'h8012, 18);
    frame("R4", 16'hB8C3, 20);

    frame("R12", 16'hC623, 16);
    frame("R12", 16'h9800, 16);
    frame("R12", 16'h81FF, 16);
    frame("R12", 16'hC0E0, 16);
    frame("R6", 16'h82C4, 16);

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule